// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block carries 36-bit words from one clock domain to another. A producer writes on `wclk` and a consumer reads on `rclk`. The two clocks run freely and may be unrelated or identical. The read and write pointers are one bit wider than the storage address. Each pointer crosses to the other domain as Gray code through two flip-flops. Each side then works out its own fill level from its own pointer and the synchronised copy of the other side's pointer.

Two options are fixed while master reset is held.

- **Timing mode.** In standard mode, a read strobe fetches the next word. The status outputs then mean "empty" on the read side and "full" on the write side. In fall-through mode, the head word is placed on the output with no strobe. The same status outputs then mean "output holds a valid word" and "there is room for another write".
- **Threshold source.** The almost-empty and almost-full thresholds come from one of three presets. They can instead be loaded after reset, either as a serial bit stream or through the first two data writes.

A partial reset empties the FIFO but keeps the timing mode and the thresholds.

Top module: `dcfifo_progflag`

## Requirements
- R1: Every word accepted on the write side leaves the read side once, in write order, with no loss or duplication. This holds with unrelated clock periods and with reads and writes in the same cycle.
- R2: Standard mode, read side:
  - `rd_stat` is 1 exactly when the FIFO holds no word.
  - A read strobe while `rd_stat`=1 is ignored, and `rdata` keeps its value.
  - An accepted read shows its word on `rdata` after the next `rclk` rising edge.
- R3: Standard mode, write side:
  - `wr_stat` is 1 exactly when 2^AW words are stored.
  - A write strobe while `wr_stat`=1 is ignored, so no extra word is ever read out.
- R4: Fall-through mode, read side:
  - The head word appears on `rdata` with `rd_stat`=1 and no read strobe.
  - The word is held while `ren`=0.
  - `ren`=1 while `rd_stat`=1 consumes it.
  - With no word waiting, `rd_stat` is 0.
- R5: Fall-through mode, write side:
  - `wr_stat`=1 means a write will be accepted.
  - The capacity is 2^AW+1 words: the memory plus the output word.
- R6: When `offs_sel` is 00, 01 or 10 during master reset, both thresholds are set to 8, 16 or 64 respectively.
- R7: Threshold flags:
  - `ae` is 1 exactly when the words held on the read side are at or below the almost-empty threshold. In fall-through mode the words held include the output word.
  - `af` is 1 exactly when the free memory slots are at or below the almost-full threshold.
- R8: Serial threshold loading:
  - It is selected by `offs_sel`=11 with `ser_mode`=1 during master reset.
  - After reset, 2·AW bits are shifted in on `sdin`, one per `wclk` while `sen`=1.
  - The order is the almost-empty value, most significant bit first, then the almost-full value in the same order.
  - Data writes are ignored until the last bit has been taken.
- R9: Parallel threshold loading:
  - It is selected by `offs_sel`=11 with `ser_mode`=0.
  - The first write strobe after master reset loads `wdata[AW-1:0]` as the almost-empty threshold. The second loads the almost-full threshold.
  - Neither of these writes enters the FIFO.
- R10: Partial reset (`prst_n`=0) empties the FIFO and keeps the timing mode and both thresholds.
- R11: Master reset (`mrst_n`=0, held over at least two edges of each clock) has two effects:
  - It empties the FIFO.
  - It latches `fwft_sel`, `offs_sel` and `ser_mode`.
- R12: Status timing after a write:
  - `af` and `wr_stat` reflect the write right after the writing `wclk` edge.
  - `rd_stat` and `ae` reflect it no later than the third `rclk` rising edge after it.
  - On the write side, each step of the Gray-coded write pointer changes at most one bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, active low; empties the FIFO and latches the configuration |
| prst_n | input | 1 | Partial reset, active low; empties the FIFO only |
| fwft_sel | input | 1 | Timing mode, sampled during master reset: 1 = fall-through |
| offs_sel | input | 2 | Threshold source, sampled during master reset: 00 = 8, 01 = 16, 10 = 64, 11 = load after reset |
| ser_mode | input | 1 | With `offs_sel`=11: 1 = serial load, 0 = parallel load |
| sen | input | 1 | Serial load enable (`wclk`) |
| sdin | input | 1 | Serial load data (`wclk`) |
| wen | input | 1 | Write strobe |
| wdata | input | DW | Write data |
| wr_stat | output | 1 | Standard mode: full; fall-through mode: input ready |
| af | output | 1 | Almost full |
| ren | input | 1 | Read strobe |
| rdata | output | DW | Read data |
| rd_stat | output | 1 | Standard mode: empty; fall-through mode: output ready |
| ae | output | 1 | Almost empty |

## Verification
The bench sweeps the fill level from empty to full, one word at a time, for each threshold source. At every level it checks both threshold flags and both status outputs within the synchroniser delay. An off-by-one compare or a stale synchronised pointer would show up as a flag flipping one word early or late.

At the full and empty boundaries, the bench pushes one extra write and issues extra reads. A design that wrote past full would hand out a stray word. One that advanced on an empty read would change `rdata`.

Random traffic on unrelated clocks checks word order against a queue, in both timing modes. This catches a pointer that skips, or a fall-through stage that drops or repeats its word. A partial reset between threshold sweeps, and a status check in fall-through mode after a partial reset, expose any design that clears its configuration along with its data.

// File: rtl/dcfifo_progflag.sv
module dcfifo_progflag #(
  parameter int DW = 36,
  parameter int AW = 8
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          fwft_sel,
  input  logic [1:0]    offs_sel,
  input  logic          ser_mode,
  input  logic          sen,
  input  logic          sdin,
  input  logic          wen,
  input  logic [DW-1:0] wdata,
  output logic          wr_stat,
  output logic          af,
  input  logic          ren,
  output logic [DW-1:0] rdata,
  output logic          rd_stat,
  output logic          ae
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;
  localparam int CW    = $clog2(2 * AW) + 1;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic          rst_n;
  assign rst_n = mrst_n & prst_n;

  // configuration, write domain
  logic          wmode, wser, loaded;
  logic [CW-1:0] bitcnt;
  logic [AW-1:0] ae_off, af_off;

  always_ff @(posedge wclk) begin
    if (!mrst_n) begin
      wmode  <= fwft_sel;
      wser   <= ser_mode;
      loaded <= (offs_sel != 2'b11);
      bitcnt <= '0;
      case (offs_sel)
        2'b00:   begin ae_off <= AW'(8);  af_off <= AW'(8);  end
        2'b01:   begin ae_off <= AW'(16); af_off <= AW'(16); end
        2'b10:   begin ae_off <= AW'(64); af_off <= AW'(64); end
        default: begin ae_off <= '0;      af_off <= '0;      end
      endcase
    end else if (!loaded) begin
      if (wser && sen) begin
        {ae_off, af_off} <= {ae_off[AW-2:0], af_off, sdin};
        bitcnt <= bitcnt + 1'b1;
        if (bitcnt == CW'(2 * AW - 1)) loaded <= 1'b1;
      end else if (!wser && wen) begin
        if (bitcnt == '0) begin
          ae_off <= wdata[AW-1:0];
          bitcnt <= CW'(1);
        end else begin
          af_off <= wdata[AW-1:0];
          loaded <= 1'b1;
        end
      end
    end
  end

  // write side
  logic [PW-1:0] wbin, wgray, rq1, rq2, wcount, wfree;
  logic          full, wr_go;

  assign wcount = wbin - g2b(rq2);
  assign full   = wcount[AW];
  assign wfree  = PW'(DEPTH) - wcount;
  assign wr_go  = wen & loaded & ~full;
  assign af     = wfree <= {1'b0, af_off};
  assign wr_stat = wmode ? ~full : full;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin <= '0; wgray <= '0; rq1 <= '0; rq2 <= '0;
    end else begin
      rq1 <= rgray;
      rq2 <= rq1;
      if (wr_go) begin
        wbin  <= wbin + 1'b1;
        wgray <= (wbin + 1'b1) ^ ((wbin + 1'b1) >> 1);
      end
    end
  end

  always_ff @(posedge wclk) if (wr_go) mem[wbin[AW-1:0]] <= wdata;

  // read side
  logic          rmode, ovalid, empty, rd_go;
  logic [PW-1:0] rbin, rgray, wq1, wq2, rcount;
  logic [PW:0]   rlevel;

  always_ff @(posedge rclk) if (!mrst_n) rmode <= fwft_sel;

  assign rcount  = g2b(wq2) - rbin;
  assign empty   = (rcount == '0);
  assign rd_go   = rmode ? (~empty & (~ovalid | ren)) : (ren & ~empty);
  assign rlevel  = {1'b0, rcount} + {{PW{1'b0}}, rmode & ovalid};
  assign ae      = rlevel <= {1'b0, 1'b0, ae_off};
  assign rd_stat = rmode ? ovalid : empty;

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin <= '0; rgray <= '0; wq1 <= '0; wq2 <= '0; ovalid <= 1'b0;
    end else begin
      wq1 <= wgray;
      wq2 <= wq1;
      if (rd_go) begin
        rbin  <= rbin + 1'b1;
        rgray <= (rbin + 1'b1) ^ ((rbin + 1'b1) >> 1);
      end
      if (rmode) ovalid <= rd_go | (ovalid & ~ren);
    end
  end

  always_ff @(posedge rclk) if (rd_go) rdata <= mem[rbin[AW-1:0]];

  // R3
  no_overflow_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (wen && full) |=> (wbin == $past(wbin)));
  // R2
  no_underflow_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (!rmode && ren && empty) |=> ($stable(rbin) && $stable(rdata)));
  // R12
  wgray_step_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);
  // R7
  ae_at_empty_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (empty && !ovalid) |-> ae);
  // R7
  af_at_full_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    full |-> af);
  // R4
  fwft_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (rmode && ovalid && !ren) |=> (ovalid && $stable(rdata)));
  // R8
  offs_hold_chk: assert property (@(posedge wclk) disable iff (!mrst_n)
    loaded |=> (loaded && $stable(ae_off) && $stable(af_off)));
endmodule

// File: tb/sim_dcfifo_progflag.sv
`timescale 1ns/100ps
module sim_dcfifo_progflag;
  localparam int DW = 36, AW = 8, DEPTH = 1 << AW;

  logic wclk = 0, rclk = 0, mrst_n = 0, prst_n = 1;
  logic fwft_sel = 0, ser_mode = 0, sen = 0, sdin = 0, wen = 0, ren = 0;
  logic [1:0] offs_sel = 0;
  logic [DW-1:0] wdata = 0, rdata;
  logic wr_stat, af, rd_stat, ae;

  dcfifo_progflag #(.DW(DW), .AW(AW)) u0 (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
    .fwft_sel(fwft_sel), .offs_sel(offs_sel), .ser_mode(ser_mode),
    .sen(sen), .sdin(sdin), .wen(wen), .wdata(wdata), .wr_stat(wr_stat),
    .af(af), .ren(ren), .rdata(rdata), .rd_stat(rd_stat), .ae(ae));

  always #4 wclk = ~wclk;
  initial begin #3; forever #5.5 rclk = ~rclk; end

  int vec = 0, bad = 0, rcv = 0;
  bit fw = 0, ldd = 1, rd_pend = 0, done = 0;
  logic [DW-1:0] q[$];

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr_cycle(input bit en, input logic [DW-1:0] d, output bit acc);
    @(negedge wclk);
    wen = en; wdata = d;
    acc = en && ldd && (fw ? wr_stat : !wr_stat);
    if (acc) q.push_back(d);
  endtask

  task automatic pop_cmp();
    if (q.size() == 0) chk("R1 unexpected word", rdata, 'x);
    else begin
      logic [DW-1:0] e = q.pop_front();
      chk("R1 order", rdata, e);
      rcv++;
    end
  endtask

  task automatic rd_cycle(input bit en);
    @(negedge rclk);
    if (rd_pend) pop_cmp();
    ren = en;
    if (fw) begin
      if (en && rd_stat) pop_cmp();
      rd_pend = 0;
    end else rd_pend = en && !rd_stat;
  endtask

  task automatic mreset(input bit f, input logic [1:0] s, input bit ser);
    @(negedge wclk);
    fwft_sel = f; offs_sel = s; ser_mode = ser; mrst_n = 0; wen = 0; sen = 0;
    @(negedge rclk); ren = 0;
    repeat (4) @(negedge rclk);
    repeat (4) @(negedge wclk);
    mrst_n = 1;
    fw = f; ldd = (s != 2'b11); rd_pend = 0; q.delete();
    repeat (3) @(negedge rclk);
  endtask

  task automatic preset();
    @(negedge wclk); wen = 0; prst_n = 0;
    @(negedge rclk); ren = 0;
    repeat (3) @(negedge rclk);
    @(negedge wclk); prst_n = 1;
    rd_pend = 0; q.delete();
    repeat (3) @(negedge rclk);
  endtask

  task automatic traffic(input int n);
    bit acc;
    rcv = 0;
    fork
      begin
        int sent = 0;
        while (sent < n) begin
          wr_cycle($urandom % 3 != 0, {4'($urandom), 32'($urandom)}, acc);
          if (acc) sent++;
        end
        wr_cycle(0, 0, acc);
      end
      begin
        while (rcv < n) rd_cycle($urandom % 2 == 0);
        rd_cycle(0);
      end
    join
    chk("R1 count", rcv, n);
  endtask

  task automatic sweep(input int aeo, input int afo, input string tag);
    bit acc;
    logic [DW-1:0] last;
    for (int c = 0; c <= DEPTH; c++) begin
      repeat (4) @(negedge rclk);
      @(negedge wclk);
      chk({tag, " R7 ae"}, ae, c <= aeo);
      chk({tag, " R7 af"}, af, (DEPTH - c) <= afo);
      chk("R2 R12 empty", rd_stat, c == 0);
      chk("R3 full", wr_stat, c == DEPTH);
      if (c < DEPTH) begin
        wr_cycle(1, DW'(c) ^ 36'h5A5A0000, acc);
        wr_cycle(0, 0, acc);
      end
    end
    wr_cycle(1, '1, acc);
    wr_cycle(0, 0, acc);
    rcv = 0;
    while (rcv < DEPTH) rd_cycle(1);
    rd_cycle(0);
    repeat (4) @(negedge rclk);
    chk("R3 write at full ignored", rd_stat, 1);
    last = rdata;
    rd_cycle(1); rd_cycle(1); rd_cycle(0);
    chk("R2 read at empty ignored", rdata, last);
  endtask

  task automatic ser_load(input logic [AW-1:0] a, input logic [AW-1:0] f);
    logic [2*AW-1:0] v = {a, f};
    for (int i = 2 * AW - 1; i >= 0; i--) begin
      @(negedge wclk); sen = 1; sdin = v[i];
    end
    @(negedge wclk); sen = 0;
    ldd = 1;
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      bad++; vec++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    bit acc;
    int tot;
    // R11 reset state, standard mode, preset 8
    mreset(0, 2'b00, 0);
    chk("R11 empty after reset", rd_stat, 1);
    chk("R11 not full after reset", wr_stat, 0);
    chk("R11 ae after reset", ae, 1);
    chk("R11 af after reset", af, 0);
    sweep(8, 8, "R6 preset 8");
    traffic(400);

    mreset(0, 2'b01, 0);
    sweep(16, 16, "R6 preset 16");
    mreset(0, 2'b10, 0);
    sweep(64, 64, "R6 preset 64");

    // R8 serial load, write before load is ignored
    mreset(0, 2'b11, 1);
    wr_cycle(1, 36'h123456789, acc);
    wr_cycle(0, 0, acc);
    repeat (5) @(negedge rclk);
    chk("R8 write before load ignored", rd_stat, 1);
    ser_load(AW'(5), AW'(7));
    repeat (5) @(negedge rclk);
    chk("R8 still empty after load", rd_stat, 1);
    sweep(5, 7, "R8 serial");
    // R10 partial reset keeps offsets
    for (int i = 0; i < 6; i++) wr_cycle(1, DW'(i), acc);
    wr_cycle(0, 0, acc);
    preset();
    chk("R10 empty after partial reset", rd_stat, 1);
    sweep(5, 7, "R10 kept offsets");

    // R9 parallel load
    mreset(0, 2'b11, 0);
    @(negedge wclk); wen = 1; wdata = 36'd3;
    @(negedge wclk); wdata = 36'd9;
    @(negedge wclk); wen = 0; ldd = 1;
    repeat (5) @(negedge rclk);
    chk("R9 offset writes not stored", rd_stat, 1);
    sweep(3, 9, "R9 parallel");

    // R11 master reset empties stored data
    for (int i = 0; i < 10; i++) wr_cycle(1, DW'(i), acc);
    wr_cycle(0, 0, acc);
    mreset(0, 2'b00, 0);
    chk("R11 empty after master reset", rd_stat, 1);
    chk("R11 ae after master reset", ae, 1);

    // R4 R5 fall-through mode
    mreset(1, 2'b00, 0);
    chk("R4 not ready when empty", rd_stat, 0);
    chk("R5 input ready when empty", wr_stat, 1);
    wr_cycle(1, 36'hABCDE1234, acc);
    wr_cycle(0, 0, acc);
    repeat (5) @(negedge rclk);
    chk("R4 word falls through", rd_stat, 1);
    chk("R4 head data", rdata, 36'hABCDE1234);
    repeat (4) @(negedge rclk);
    chk("R4 held without strobe", rd_stat, 1);
    rcv = 0;
    rd_cycle(1); rd_cycle(0);
    chk("R4 consumed count", rcv, 1);
    repeat (4) @(negedge rclk);
    chk("R4 not ready after consume", rd_stat, 0);
    traffic(400);

    tot = 0;
    for (int i = 0; i < DEPTH + 10; i++) begin wr_cycle(1, DW'(i + 7), acc); tot += acc; end
    wr_cycle(0, 0, acc);
    repeat (10) @(negedge rclk);
    for (int i = 0; i < 5; i++) begin wr_cycle(1, DW'(i), acc); tot += acc; end
    wr_cycle(0, 0, acc);
    chk("R5 capacity", tot, DEPTH + 1);
    chk("R5 not ready when full", wr_stat, 0);
    rcv = 0;
    while (rcv < DEPTH + 1) rd_cycle(1);
    rd_cycle(0);
    repeat (4) @(negedge rclk);
    chk("R4 drained", rd_stat, 0);

    // R10 partial reset keeps fall-through mode
    mreset(1, 2'b01, 0);
    for (int i = 0; i < 5; i++) wr_cycle(1, DW'(i + 100), acc);
    wr_cycle(0, 0, acc);
    repeat (5) @(negedge rclk);
    chk("R4 ready before partial reset", rd_stat, 1);
    preset();
    chk("R10 mode kept rd_stat", rd_stat, 0);
    chk("R10 mode kept wr_stat", wr_stat, 1);
    chk("R10 ae after partial reset", ae, 1);
    wr_cycle(1, 36'h0FEEDBEEF, acc);
    wr_cycle(0, 0, acc);
    repeat (5) @(negedge rclk);
    rcv = 0;
    rd_cycle(1); rd_cycle(0);
    chk("R10 only new word", rcv, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule